// File: doc/BRIEF.md
# Quadrature-Phased Fetch/Execute Sequencer

This block paces a two-stage instruction pipeline from one oscillator clock. A two-bit phase counter splits every four oscillator periods into one instruction cycle. The four phases, Q1 to Q4, are one-hot enables on that same clock, so the design has no derived clocks. The program counter drives the program-memory address. At the end of Q3 the word returned by program memory is caught in a fetch latch. At the boundary into the next Q1 that word moves into the instruction register, and the program counter steps to the next address. While one instruction executes, the next one is being fetched.

The strobes in the execute cycle stand in for the decoder, ALU and register file, none of which are part of this block. An operand-read strobe marks Q2 and a destination-write strobe marks Q4. A taken branch is reported during Q4 of the executing cycle and loads the target into the program counter. The word that was already prefetched then runs as a forced no-operation while the target is fetched, so any change of flow costs one extra instruction cycle. A phase-clock output runs at one quarter of the oscillator rate.

Top module: `qphase_seq`

## Requirements
- R1: `q_phase` is one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. It steps Q1→Q2→Q3→Q4→Q1 on every clock and is Q1 while and directly after reset.
- R2: `phase_clk` is 1 during Q1 and Q2 and 0 during Q3 and Q4.
- R3: While reset is low and just after it is released, `pmem_addr` is 0, `ir_word` is 0 and `exec_nop` is 1. The first instruction cycle therefore executes a no-operation.
- R4: `pmem_addr` changes only when Q1 begins. In straight-line flow it is one more than in the previous instruction cycle, and it holds its value through Q2 to Q4.
- R5: The value of `pmem_rdata` at the end of Q3 appears on `ir_word` for the whole of the following instruction cycle.
- R6: In a cycle with `exec_nop` = 0, `dmem_rd` is 1 exactly in Q2 and `dmem_wr` is 1 exactly in Q4. In a cycle with `exec_nop` = 1, both stay 0.
- R7: If `br_taken` = 1 in Q4 of a cycle with `exec_nop` = 0, the next cycle has `pmem_addr` = `br_target`, `exec_nop` = 1, and `ir_word` = the word prefetched from the address after the branch. The cycle after that carries the target's word with `exec_nop` = 0 and `pmem_addr` = target + 1.
- R8: `br_taken` asserted only in Q1, Q2 or Q3 has no effect on the flow.
- R9: `br_taken` asserted in Q4 of a cycle with `exec_nop` = 1 is ignored. This covers the first cycle after reset and the flush cycle itself.
- R10: The program counter wraps modulo 2^AW: from all ones it advances to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmem_addr | output | AW | Program-memory address (program counter) |
| pmem_rdata | input | IW | Instruction word from program memory |
| br_taken | input | 1 | Branch taken by the executing instruction, valid in Q4 |
| br_target | input | AW | Branch target address |
| dmem_rd | output | 1 | Operand-read strobe (Q2) |
| dmem_wr | output | 1 | Destination-write strobe (Q4) |
| q_phase | output | 4 | One-hot phase enables, bit 0 = Q1 |
| phase_clk | output | 1 | Instruction-rate clock, high in Q1/Q2 |
| ir_word | output | IW | Instruction register |
| exec_nop | output | 1 | Current execute cycle is a forced no-operation |

## Verification
The hardest case to reach is a branch request that arrives while the pipeline is already flushing. It needs a taken branch first, followed one instruction cycle later by a second request placed exactly in Q4, the only phase that is sampled. The directed tasks count phases from reset release, which lets them place `br_taken` in a chosen phase of a chosen cycle. The same mechanism puts requests in Q1 to Q3 to show that those phases are ignored, and issues a branch to the last address to show the counter wrapping.

// File: rtl/qphase_seq.sv
module qphase_seq #(
  parameter int AW = 10,
  parameter int IW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] pmem_addr,
  input  logic [IW-1:0] pmem_rdata,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  output logic          dmem_rd,
  output logic          dmem_wr,
  output logic [3:0]    q_phase,
  output logic          phase_clk,
  output logic [IW-1:0] ir_word,
  output logic          exec_nop
);

  localparam logic [1:0] PH_Q1 = 2'd0;
  localparam logic [1:0] PH_Q3 = 2'd2;
  localparam logic [1:0] PH_Q4 = 2'd3;

  logic [1:0]    ph;
  logic [AW-1:0] pc;
  logic [IW-1:0] fetch_q;
  logic [IW-1:0] ir_q;
  logic          nop_q;
  logic          clk_q;

  wire take_br = br_taken && !nop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_Q1;
      clk_q   <= 1'b1;
      pc      <= '0;
      fetch_q <= '0;
      ir_q    <= '0;
      nop_q   <= 1'b1;
    end else begin
      ph    <= ph + 2'd1;
      clk_q <= (ph == PH_Q4) || (ph == PH_Q1);
      if (ph == PH_Q3)
        fetch_q <= pmem_rdata;
      if (ph == PH_Q4) begin
        ir_q <= fetch_q;
        if (take_br) begin
          pc    <= br_target;
          nop_q <= 1'b1;
        end else begin
          pc    <= pc + AW'(1);
          nop_q <= 1'b0;
        end
      end
    end
  end

  assign q_phase   = 4'b0001 << ph;
  assign phase_clk = clk_q;
  assign pmem_addr = pc;
  assign ir_word   = ir_q;
  assign exec_nop  = nop_q;
  assign dmem_rd   = q_phase[1] && !nop_q;
  assign dmem_wr   = q_phase[3] && !nop_q;

endmodule

// File: rtl/qphase_seq_chk.sv
module qphase_seq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pmem_addr,
  input logic          br_taken,
  input logic [AW-1:0] br_target,
  input logic          dmem_rd,
  input logic          dmem_wr,
  input logic [3:0]    q_phase,
  input logic          phase_clk,
  input logic          exec_nop
);

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_phase) == 1); // R1

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    q_phase[3] |=> q_phase[0]); // R1

  AST_CLK_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clk == (q_phase[0] || q_phase[1])); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !q_phase[3] |=> $stable(pmem_addr)); // R4

  AST_RD_IN_Q2: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd |-> (q_phase[1] && !exec_nop)); // R6

  AST_WR_IN_Q4: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr |-> (q_phase[3] && !exec_nop)); // R6

  AST_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (q_phase[3] && br_taken && !exec_nop) |=> (exec_nop && pmem_addr == $past(br_target))); // R7

  AST_OFFPHASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_phase[3] && br_taken) |=> $stable(pmem_addr)); // R8

  AST_NOP_BRANCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (q_phase[3] && exec_nop) |=> (!exec_nop && pmem_addr == $past(pmem_addr) + AW'(1))); // R9

endmodule

bind qphase_seq qphase_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .br_taken(br_taken),
  .br_target(br_target), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
  .q_phase(q_phase), .phase_clk(phase_clk), .exec_nop(exec_nop)
);

// File: tb/qphase_seq_tb_top.sv
module qphase_seq_tb_top;
  localparam int AW = 10;
  localparam int IW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] pmem_addr;
  logic [IW-1:0] pmem_rdata;
  logic          br_taken = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic          dmem_rd, dmem_wr, phase_clk, exec_nop;
  logic [3:0]    q_phase;
  logic [IW-1:0] ir_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_addr;
  logic [IW-1:0] exp_ir;
  logic          exp_nop;

  always #2 clk = ~clk;

  function automatic logic [IW-1:0] wfun(input logic [AW-1:0] a);
    return {4'h9, a} ^ 14'h0A53;
  endfunction

  assign pmem_rdata = wfun(pmem_addr);

  qphase_seq #(.AW(AW), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .pmem_rdata(pmem_rdata),
    .br_taken(br_taken), .br_target(br_target), .dmem_rd(dmem_rd),
    .dmem_wr(dmem_wr), .q_phase(q_phase), .phase_clk(phase_clk),
    .ir_word(ir_word), .exec_nop(exec_nop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    exp_addr = '0;
    exp_ir   = '0;
    exp_nop  = 1'b1;
  endtask

  task automatic run_cycle(input bit br, input int br_ph, input logic [AW-1:0] tgt);
    bit taken;
    for (int p = 0; p < 4; p++) begin
      chk("R1 q_phase", q_phase, 1 << p);
      chk("R2 phase_clk", phase_clk, (p < 2) ? 1 : 0);
      chk("R4 pmem_addr", pmem_addr, exp_addr);
      chk("R5 ir_word", ir_word, exp_ir);
      chk("R7 exec_nop", exec_nop, exp_nop);
      chk("R6 dmem_rd", dmem_rd, (p == 1 && !exp_nop) ? 1 : 0);
      chk("R6 dmem_wr", dmem_wr, (p == 3 && !exp_nop) ? 1 : 0);
      br_taken  = br && (p == br_ph);
      br_target = tgt;
      @(negedge clk);
    end
    br_taken = 1'b0;
    taken = br && br_ph == 3 && !exp_nop;
    exp_ir   = wfun(exp_addr);
    exp_addr = taken ? tgt : exp_addr + AW'(1);
    exp_nop  = taken;
  endtask

  task automatic plain(input int n);
    for (int i = 0; i < n; i++) run_cycle(1'b0, 0, '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 addr in reset", pmem_addr, 0);
    chk("R3 ir in reset", ir_word, 0);
    chk("R3 nop in reset", exec_nop, 1);
    chk("R1 phase in reset", q_phase, 1);
    rst_n = 1'b1;
    model_reset();
    chk("R3 nop after release", exec_nop, 1);
  endtask

  task automatic t_straight();
    plain(6);
    chk("R4 addr after straight run", pmem_addr, exp_addr);
  endtask

  task automatic t_branch();
    logic [AW-1:0] pre;
    pre = exp_addr;
    run_cycle(1'b1, 3, 10'd300);
    chk("R7 target address", pmem_addr, 300);
    chk("R7 flushed word", ir_word, wfun(pre));
    chk("R7 flush flag", exec_nop, 1);
    plain(1);
    chk("R7 target word", ir_word, wfun(10'd300));
    chk("R7 addr after target", pmem_addr, 301);
    plain(2);
  endtask

  task automatic t_offphase();
    for (int ph = 0; ph < 3; ph++) begin
      logic [AW-1:0] nxt;
      nxt = exp_addr + AW'(1);
      run_cycle(1'b1, ph, 10'd77);
      chk("R8 no redirect", pmem_addr, nxt);
      chk("R8 no flush", exec_nop, 0);
    end
  endtask

  task automatic t_branch_in_flush();
    logic [AW-1:0] nxt;
    run_cycle(1'b1, 3, 10'd500);
    run_cycle(1'b1, 3, 10'd12);
    chk("R9 flush-cycle branch ignored addr", pmem_addr, 501);
    chk("R9 flush-cycle branch ignored nop", exec_nop, 0);
    plain(1);
    t_reset();
    run_cycle(1'b1, 3, 10'd44);
    chk("R9 first-cycle branch ignored", pmem_addr, 1);
    nxt = exp_addr;
    plain(1);
    chk("R9 flow continues", pmem_addr, nxt + AW'(1));
  endtask

  task automatic t_wrap();
    run_cycle(1'b1, 3, 10'h3FF);
    chk("R10 at top", pmem_addr, 1023);
    plain(1);
    chk("R10 wrapped", pmem_addr, 0);
    plain(1);
    chk("R10 after wrap", pmem_addr, 1);
  endtask

  task automatic t_midrun_reset();
    plain(1);
    @(negedge clk);
    @(negedge clk);
    t_reset();
    plain(3);
  endtask

  initial begin
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    t_reset();
    t_straight();
    t_branch();
    t_offphase();
    t_branch_in_flush();
    t_wrap();
    t_midrun_reset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule